// File: doc/BRIEF.md
# Programmable Feedback Divider with Transmit Offset

This block divides a stream of oscillator-derived ticks by a programmable ratio and marks the end of each division period with a one-clock pulse. That pulse feeds a phase comparator. An identical copy of the pulse is driven on a second port, so the divider can also be used on its own. The ratio comes from a 14-bit parallel word.

A mode select can raise the ratio by a fixed offset of 856 before the ratio is loaded. A transceiver can then keep one channel word for both directions, and the mode pin moves the synthesised frequency by the intermediate frequency. The effective ratio is kept within the legal range of 3 to 16383. The word and the mode are taken only when the counter reloads, so a change made partway through a period never shortens or stretches that period.

The tick input is a plain enable that is sampled on each clock. It has no handshake and applies no back-pressure, because the block accepts a tick on every cycle. The pulse outputs are also plain and unacknowledged.

Top module: `ndiv_core`

## Requirements
- R1: While `rst_n` is low, both `fv_pulse` and `fv_ext` are 0 and the count is cleared. The first tick after reset is therefore a reload, and it produces a pulse.
- R2: With `trx_sel` = 1 and ticks on every clock, pulses are exactly N ticks apart for any N from 3 to 16383, where N is `n_word` (bit 0 is the least significant bit).
- R3: With `trx_sel` = 0, the period becomes N + 856 ticks.
- R4: When N plus the offset exceeds 16383, the period is 16383 ticks.
- R5: When the effective ratio would be 0, 1 or 2, the period is 3 ticks.
- R6: `fv_pulse` is high for exactly one clock, in the clock after the reload tick.
- R7: `fv_ext` equals `fv_pulse` on every clock.
- R8: `n_word` and `trx_sel` are used only on the reload tick. A change between reloads leaves the current period unchanged and sets the length of the next period.
- R9: A clock with `tick` low does not advance the count and cannot produce a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oscillator-derived count enable, one tick per clock at most |
| n_word | input | 14 | Programmed division ratio |
| trx_sel | input | 1 | 0 adds the offset of 856; 1 (the idle level) adds nothing |
| fv_pulse | output | 1 | Divided pulse sent to the phase comparator |
| fv_ext | output | 1 | Buffered copy of the divided pulse for external use |

## Verification
A tick that reloads the counter on clock edge k makes the pulse visible after edge k. The pulse stays high only until edge k+1. Every period is measured from the falling edge where one pulse is seen to the falling edge where the next is seen, so the number of clocks counted equals the number of ticks in the period. Inputs are changed only on falling edges. A setting therefore reaches the next reload tick, and the first pulse seen after a change marks the start of the first period that uses the new setting.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
  localparam int DEF_WIDTH  = 14;
  localparam int DEF_OFFSET = 856;
  localparam int DEF_MINDIV = 3;

  typedef enum logic {
    TRX_OFFSET = 1'b0,
    TRX_PLAIN  = 1'b1
  } trx_mode_e;
endpackage

// File: rtl/ndiv_ratio.sv
module ndiv_ratio #(
  parameter int WIDTH  = ndiv_pkg::DEF_WIDTH,
  parameter int OFFSET = ndiv_pkg::DEF_OFFSET,
  parameter int MINDIV = ndiv_pkg::DEF_MINDIV
) (
  input  logic [WIDTH-1:0] n_word,
  input  logic             trx_sel,
  output logic [WIDTH-1:0] eff_div
);
  localparam logic [WIDTH:0]   MAXV = {1'b0, {WIDTH{1'b1}}};
  localparam logic [WIDTH:0]   MINV = (WIDTH+1)'(MINDIV);
  localparam logic [WIDTH:0]   OFFV = (WIDTH+1)'(OFFSET);

  logic [WIDTH:0] sum;

  generate
    if (OFFSET == 0) begin : g_no_add
      assign sum = {1'b0, n_word};
    end else begin : g_add
      always_comb begin
        sum = {1'b0, n_word};
        if (trx_sel == ndiv_pkg::TRX_OFFSET) sum = {1'b0, n_word} + OFFV;
      end
    end
  endgenerate

  always_comb begin
    if (sum > MAXV)      eff_div = MAXV[WIDTH-1:0];
    else if (sum < MINV) eff_div = MINV[WIDTH-1:0];
    else                 eff_div = sum[WIDTH-1:0];
  end
endmodule

// File: rtl/ndiv_count.sv
module ndiv_count #(
  parameter int WIDTH = ndiv_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIDTH-1:0] load_val,
  output logic             reload
);
  logic [WIDTH-1:0] remain;

  assign reload = tick && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain <= '0;
    else if (reload) remain <= load_val - WIDTH'(1);
    else if (tick)   remain <= remain - WIDTH'(1);
  end
endmodule

// File: rtl/ndiv_pulse_out.sv
module ndiv_pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic fv_pulse,
  output logic fv_ext
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_pulse <= 1'b0;
      fv_ext   <= 1'b0;
    end else begin
      fv_pulse <= reload;
      fv_ext   <= reload;
    end
  end
endmodule

// File: rtl/ndiv_core.sv
module ndiv_core #(
  parameter int WIDTH  = ndiv_pkg::DEF_WIDTH,
  parameter int OFFSET = ndiv_pkg::DEF_OFFSET,
  parameter int MINDIV = ndiv_pkg::DEF_MINDIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIDTH-1:0] n_word,
  input  logic             trx_sel,
  output logic             fv_pulse,
  output logic             fv_ext
);
  logic [WIDTH-1:0] eff_div;
  logic             reload;

  ndiv_ratio #(.WIDTH(WIDTH), .OFFSET(OFFSET), .MINDIV(MINDIV)) u_ratio (
    .n_word  (n_word),
    .trx_sel (trx_sel),
    .eff_div (eff_div)
  );

  ndiv_count #(.WIDTH(WIDTH)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load_val (eff_div),
    .reload   (reload)
  );

  ndiv_pulse_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload),
    .fv_pulse (fv_pulse),
    .fv_ext   (fv_ext)
  );
endmodule

// File: rtl/ndiv_core_chk.sv
module ndiv_core_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic fv_pulse,
  input logic fv_ext
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !fv_pulse && !fv_ext); // R1
  AST_EXT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n) fv_ext == fv_pulse); // R7
  AST_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) fv_pulse |=> !fv_pulse); // R6
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n) fv_pulse |=> !fv_pulse ##1 !fv_pulse); // R5
  AST_NO_TICK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> !fv_pulse); // R9
endmodule

bind ndiv_core ndiv_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .fv_pulse (fv_pulse),
  .fv_ext   (fv_ext)
);

// File: tb/ndiv_core_test.sv
module ndiv_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [13:0] n_word = 14'd10;
  logic        trx_sel = 1'b1;
  logic        fv_pulse, fv_ext;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ext_bad = 1'b0;

  always #2.5 clk = ~clk;

  ndiv_core uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .n_word(n_word),
    .trx_sel(trx_sel), .fv_pulse(fv_pulse), .fv_ext(fv_ext)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n && fv_ext !== fv_pulse) ext_bad = 1'b1;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_pulse();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (fv_pulse) return;
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      n++;
      if (fv_pulse) return;
    end
  endtask

  task automatic measure(input string req, input int nw, input bit trx, input int exp);
    int n;
    @(negedge clk);
    n_word = 14'(nw); trx_sel = trx; tick = 1'b1;
    sync_pulse();
    gap(n);
    check(req, n, exp);
  endtask

  task automatic t_reset();
    check("R1 fv_pulse in reset", int'(fv_pulse), 0);
    check("R1 fv_ext in reset", int'(fv_ext), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); tick = 1'b1;
    @(negedge clk);
    check("R1 first tick reloads", int'(fv_pulse), 1);
  endtask

  task automatic t_width();
    @(negedge clk);
    n_word = 14'd8; trx_sel = 1'b1; tick = 1'b1;
    sync_pulse();
    @(negedge clk);
    check("R6 pulse one clock wide", int'(fv_pulse), 0);
  endtask

  task automatic t_sample_at_reload();
    int n;
    @(negedge clk);
    n_word = 14'd10; trx_sel = 1'b1; tick = 1'b1;
    sync_pulse();
    sync_pulse();
    repeat (3) @(negedge clk);
    n_word = 14'd20;
    n = 3;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      if (fv_pulse) break;
    end
    check("R8 current period kept", n, 10);
    gap(n);
    check("R8 next period uses new word", n, 20);
  endtask

  task automatic t_gated_ticks();
    int c;
    @(negedge clk);
    n_word = 14'd5; trx_sel = 1'b1; tick = 1'b1;
    sync_pulse();
    c = 0;
    for (int i = 0; i < 100; i++) begin
      tick = c[0];
      @(negedge clk); c++;
      if (fv_pulse) break;
    end
    check("R9 half-rate ticks double period", c, 10);
    tick = 1'b0;
    c = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (fv_pulse) c++;
    end
    check("R9 no pulse without ticks", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_width();
    measure("R2 N=3", 3, 1'b1, 3);
    measure("R2 N=100", 100, 1'b1, 100);
    measure("R2 N=1000", 1000, 1'b1, 1000);
    measure("R3 offset N=1000", 1000, 1'b0, 1856);
    measure("R5 N=0", 0, 1'b1, 3);
    measure("R5 N=2", 2, 1'b1, 3);
    measure("R4 N=16383 plain", 16383, 1'b1, 16383);
    measure("R4 N=16000 offset clamps", 16000, 1'b0, 16383);
    t_sample_at_reload();
    t_gated_ticks();
    check("R7 fv_ext mirrors fv_pulse", int'(ext_bad), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule